// File: doc/BRIEF.md
# Byte Adder with Decimal Adjust

This block is the eight-bit arithmetic datapath of a small controller. From the accumulator, a source byte, the stored carry and half-carry flags and a two-bit operation code, it forms a plain binary sum, a sum that includes the incoming carry, or the decimal correction that turns the binary sum of two packed-BCD bytes into a packed-BCD result. Next to the result byte it gives carry, auxiliary (half) carry and signed overflow flags. Each flag has its own write enable, so the flag register outside the block keeps every flag that the operation does not touch.

The arithmetic is combinational. A parameter selects an optional output register that adds one clock of latency. With the default setting the register is present, and it clears to all zeros on an asynchronous active-low reset. The decimal correction uses only the stored flags and the accumulator, and it completes in the same single cycle as the additions.

Top module: `bcd_byte_adder`

## Requirements
- R1: Operation code 0 (plain add) gives a result of acc_i + src_i modulo 256. cy_o is 1 exactly when the sum carries out of bit 7.
- R2: Operation code 1 (add with carry) gives a result of acc_i + src_i + cy_i modulo 256. Its carry is defined as in R1.
- R3: For operation codes 0 and 1, ac_o is 1 exactly when the sum of the two low nibbles, plus the carry-in used, exceeds 15. It is 0 otherwise.
- R4: For operation codes 0 and 1, ov_o is 1 exactly when one, but not both, of the carries out of bit 6 and bit 7 occurs. This is the same as the signed sum falling outside -128..127. For example, C3h + AAh gives 6Dh with cy_o=1, ac_o=0 and ov_o=1.
- R5: Operation codes 0 and 1 raise all three write enables: cy_we_o, ac_we_o and ov_we_o.
- R6: Operation code 2 (decimal adjust) first adds 06h to the accumulator when its low nibble is above 9 or ac_i is 1. A carry out of bit 7 from this step sets the carry.
- R7: The adjust then adds 60h when the carry (cy_i, or the carry from the first step) is 1 or when the high nibble is above 9. A carry out sets the carry. cy_o is never 0 while cy_i is 1. For example, C9h with both flags clear adjusts to 29h with carry set, which is the BCD sum 30 + 99.
- R8: Operation code 2 raises only cy_we_o. It drives ac_o and ov_o to 0, and the total amount added to the accumulator is one of 00h, 06h, 60h or 66h.
- R9: Operation code 3 (hold) passes acc_i to the result. All write enables are 0 and all flags are 0.
- R10: With the output register present, each output reflects the inputs sampled at the previous rising clock edge. While rst_n is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_i | input | 2 | Operation: 0 add, 1 add with carry, 2 decimal adjust, 3 hold |
| acc_i | input | 8 | Accumulator operand |
| src_i | input | 8 | Source operand (ignored by decimal adjust and hold) |
| cy_i | input | 1 | Stored carry flag |
| ac_i | input | 1 | Stored auxiliary-carry flag |
| res_o | output | 8 | Result byte |
| cy_o | output | 1 | New carry flag |
| ac_o | output | 1 | New auxiliary-carry flag |
| ov_o | output | 1 | New overflow flag |
| cy_we_o | output | 1 | Carry flag write enable |
| ac_we_o | output | 1 | Auxiliary-carry write enable |
| ov_we_o | output | 1 | Overflow write enable |

## Verification
Add with carry is swept over every accumulator and source byte with both carry-in values. This separates each carry-in path and every carry out of bits 3, 6 and 7. A strided sweep of the plain add, run with the stored carry held at 1, shows that this carry cannot leak into the sum. The decimal adjust is tried on all 256 accumulator values under all four stored carry and half-carry combinations. This separates the low-digit trigger from the high-digit trigger and shows that a carry already set survives. Directed vectors with literal expected values pin the signed-overflow example and the BCD 30 + 99 case independently of the bench model.

// File: rtl/bcdadd_pkg.sv
package bcdadd_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_ADDC = 2'd1,
    OP_DADJ = 2'd2,
    OP_HOLD = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } flag_set_t;

  // decimal digit exceeds nine
  function automatic logic digit_over9(input logic [3:0] d);
    return d > 4'd9;
  endfunction

  // signed overflow from the two top carries
  function automatic logic ovf_from_carries(input logic c_pen, input logic c_top);
    return c_pen ^ c_top;
  endfunction

endpackage

// File: rtl/bin_adder.sv
module bin_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_top_o,
  output logic         c_pen_o,
  output logic         c_half_o
);
  localparam int H = W / 2;

  logic [W:0]   full_s;
  logic [W-1:0] pen_s;
  logic [H:0]   half_s;

  assign full_s = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign pen_s  = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + {{(W-1){1'b0}}, cin_i};
  assign half_s = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + {{H{1'b0}}, cin_i};

  assign sum_o    = full_s[W-1:0];
  assign c_top_o  = full_s[W];
  assign c_pen_o  = pen_s[W-1];
  assign c_half_o = half_s[H];
endmodule

// File: rtl/dec_adjust.sv
module dec_adjust import bcdadd_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic         cy_i,
  input  logic         ac_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  localparam int NIB = 4;
  localparam int ND  = W / NIB;

  logic [W-1:0] val    [ND+1];
  logic [ND:0]  cy_run;

  assign val[0]    = acc_i;
  assign cy_run[0] = cy_i;

  for (genvar g = 0; g < ND; g++) begin : g_digit
    logic [NIB-1:0] dig;
    logic           trig;
    logic [W:0]     ext;
    assign dig = val[g][NIB*g +: NIB];
    // lowest digit is triggered by the half carry, higher ones by the running carry
    if (g == 0) begin : g_lo
      assign trig = digit_over9(dig) | ac_i;
    end else begin : g_hi
      assign trig = digit_over9(dig) | cy_run[g];
    end
    assign ext          = {1'b0, val[g]} + (trig ? ((W+1)'(6) << (NIB*g)) : '0);
    assign val[g+1]     = ext[W-1:0];
    assign cy_run[g+1]  = cy_run[g] | ext[W];
  end

  assign res_o = val[ND];
  assign cy_o  = cy_run[ND];
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int BW      = 14,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] d_i,
  output logic [BW-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= d_i;
    end
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/bcd_byte_adder.sv
module bcd_byte_adder import bcdadd_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              cy_i,
  input  logic              ac_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              ov_o,
  output logic              cy_we_o,
  output logic              ac_we_o,
  output logic              ov_we_o
);
  localparam int BUS_W = DATA_W + 6;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // named internal events
  logic              add_cin;
  logic [DATA_W-1:0] add_sum;
  logic              carry7, carry6, carry3;
  logic [DATA_W-1:0] dadj_res;
  logic              dadj_cy;

  assign add_cin = (op == OP_ADDC) & cy_i;

  bin_adder #(.W(DATA_W)) u_add (
    .a_i(acc_i), .b_i(src_i), .cin_i(add_cin),
    .sum_o(add_sum), .c_top_o(carry7), .c_pen_o(carry6), .c_half_o(carry3)
  );

  dec_adjust #(.W(DATA_W)) u_dadj (
    .acc_i(acc_i), .cy_i(cy_i), .ac_i(ac_i),
    .res_o(dadj_res), .cy_o(dadj_cy)
  );

  logic [DATA_W-1:0] nxt_res;
  flag_set_t         nxt_flg, nxt_we;

  always_comb begin
    nxt_res = acc_i;
    nxt_flg = '0;
    nxt_we  = '0;
    unique case (op)
      OP_ADD, OP_ADDC: begin
        nxt_res = add_sum;
        nxt_flg = '{cy: carry7, ac: carry3, ov: ovf_from_carries(carry6, carry7)};
        nxt_we  = '{cy: 1'b1, ac: 1'b1, ov: 1'b1};
      end
      OP_DADJ: begin
        nxt_res    = dadj_res;
        nxt_flg.cy = dadj_cy;
        nxt_we.cy  = 1'b1;
      end
      default: begin
        nxt_res = acc_i;
      end
    endcase
  end

  logic [BUS_W-1:0] bus_d, bus_q;
  assign bus_d = {nxt_res, nxt_flg, nxt_we};

  out_stage #(.BW(BUS_W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .d_i(bus_d), .q_o(bus_q)
  );

  assign {res_o, cy_o, ac_o, ov_o, cy_we_o, ac_we_o, ov_we_o} = bus_q;
endmodule

// File: rtl/bcd_adder_chk.sv
module bcd_adder_chk #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   op_i,
  input logic [W-1:0] acc_i,
  input logic         cy_i,
  input logic [W-1:0] res_o,
  input logic         cy_o,
  input logic         ac_o,
  input logic         ov_o,
  input logic         cy_we_o,
  input logic         ac_we_o,
  input logic         ov_we_o
);
  if (REG_OUT) begin : g_seq
    logic [W-1:0] acc_q;
    logic [W-1:0] dlt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_i;
    end
    assign dlt = res_o - acc_q;

    // R5
    add_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd0 || op_i == 2'd1) |=> (cy_we_o && ac_we_o && ov_we_o));

    // R7
    dadj_carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd2 && cy_i) |=> cy_o);

    // R8
    dadj_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd2) |=> (cy_we_o && !ac_we_o && !ov_we_o && !ac_o && !ov_o));

    // R8
    dadj_net_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd2) |=> (dlt == 8'h00 || dlt == 8'h06 || dlt == 8'h60 || dlt == 8'h66));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd3) |=> (dlt == '0 && !cy_we_o && !ac_we_o && !ov_we_o && !cy_o));
  end

  // R9
  quiet_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ov_we_o |-> !ov_o);
endmodule

bind bcd_byte_adder bcd_adder_chk #(.W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .cy_i(cy_i),
  .res_o(res_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o),
  .cy_we_o(cy_we_o), .ac_we_o(ac_we_o), .ov_we_o(ov_we_o)
);

// File: tb/sim_bcd_byte_adder.sv
module sim_bcd_byte_adder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [7:0] acc_i = 8'hFF, src_i = 8'hFF;
  logic       cy_i = 1'b1, ac_i = 1'b1;
  logic [7:0] res_o;
  logic       cy_o, ac_o, ov_o, cy_we_o, ac_we_o, ov_we_o;

  always #10 clk = ~clk;

  bcd_byte_adder u0 (.*);

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] res;
    logic cy, ac, ov, cyw, acw, ovw;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  task automatic chk(input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic exp_t model(input int op, input int a, input int s, input int c, input int h);
    exp_t e;
    int v, cc, sa, ss, cin, ssum;
    e = '0;
    e.op = 2'(op);
    if (op == 0 || op == 1) begin
      cin = (op == 1) ? c : 0;
      v = a + s + cin;
      sa = (a > 127) ? a - 256 : a;
      ss = (s > 127) ? s - 256 : s;
      ssum = sa + ss + cin;
      e.res = 8'(v % 256);
      e.cy = (v > 255);
      e.ac = ((a % 16) + (s % 16) + cin) > 15;
      e.ov = (ssum > 127) || (ssum < -128);
      e.cyw = 1; e.acw = 1; e.ovw = 1;
    end else if (op == 2) begin
      v = a; cc = c;
      if ((v % 16) > 9 || h != 0) begin v = v + 6; if (v > 255) cc = 1; v = v % 256; end
      if ((v / 16) > 9 || cc != 0) begin v = v + 96; if (v > 255) cc = 1; v = v % 256; end
      e.res = 8'(v); e.cy = cc[0]; e.cyw = 1;
    end else begin
      e.res = 8'(a);
    end
    return e;
  endfunction

  task automatic compare_front();
    exp_t e;
    string t_res, t_cy;
    e = exp_q.pop_front();
    case (e.op)
      2'd0: begin t_res = "R1"; t_cy = "R1"; end
      2'd1: begin t_res = "R2"; t_cy = "R2"; end
      2'd2: begin t_res = "R6 R7"; t_cy = "R7"; end
      default: begin t_res = "R9"; t_cy = "R9"; end
    endcase
    chk(t_res, "result", int'(res_o), int'(e.res));
    chk(t_cy, "carry", int'(cy_o), int'(e.cy));
    chk((e.op < 2) ? "R3" : "R8 R9", "aux carry", int'(ac_o), int'(e.ac));
    chk((e.op < 2) ? "R4" : "R8 R9", "overflow", int'(ov_o), int'(e.ov));
    chk((e.op < 2) ? "R5" : "R8 R9", "write enables",
        int'({cy_we_o, ac_we_o, ov_we_o}), int'({e.cyw, e.acw, e.ovw}));
  endtask

  // drive one operation; the previous one is checked first (one-cycle latency, R10)
  task automatic step_e(input int op, input int a, input int s, input int c, input int h, input exp_t e);
    @(negedge clk);
    if (exp_q.size() > 0) compare_front();
    op_i = 2'(op); acc_i = 8'(a); src_i = 8'(s); cy_i = c[0]; ac_i = h[0];
    exp_q.push_back(e);
  endtask

  task automatic step(input int op, input int a, input int s, input int c, input int h);
    step_e(op, a, s, c, h, model(op, a, s, c, h));
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    exp_t lit;
    // R10: outputs held at zero during reset
    repeat (2) @(negedge clk);
    chk("R10", "reset result", int'(res_o), 0);
    chk("R10", "reset flags", int'({cy_o, ac_o, ov_o}), 0);
    chk("R10", "reset enables", int'({cy_we_o, ac_we_o, ov_we_o}), 0);
    rst_n = 1'b1;

    // R4 literal: C3h + AAh -> 6Dh, cy=1 ac=0 ov=1
    lit = '{op: 2'd0, res: 8'h6D, cy: 1, ac: 0, ov: 1, cyw: 1, acw: 1, ovw: 1};
    step_e(0, 'hC3, 'hAA, 0, 0, lit);
    // R2 literal: same with carry in -> 6Eh
    lit.op = 2'd1; lit.res = 8'h6E;
    step_e(1, 'hC3, 'hAA, 1, 0, lit);
    // R7 literal: 30h + 99h = C9h, then adjust -> 29h carry set
    lit = '{op: 2'd0, res: 8'hC9, cy: 0, ac: 0, ov: 0, cyw: 1, acw: 1, ovw: 1};
    step_e(0, 'h30, 'h99, 0, 0, lit);
    lit = '{op: 2'd2, res: 8'h29, cy: 1, ac: 0, ov: 0, cyw: 1, acw: 0, ovw: 0};
    step_e(2, 'hC9, 'h00, 0, 0, lit);
    // R9 hold passes the accumulator, src and flags ignored
    step(3, 'h5A, 'hFF, 1, 1);
    step(3, 'hA5, 'h00, 0, 1);

    // R2 R3 R4: exhaustive add with carry
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 256; a++)
        for (int s = 0; s < 256; s++)
          step(1, a, s, c, a & 1);
    // R1: plain add ignores the stored carry
    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 256; s += 3)
        step(0, a, s, 1, 1);
    // R6 R7 R8: decimal adjust over all accumulators and flag pairs
    for (int f = 0; f < 4; f++)
      for (int a = 0; a < 256; a++)
        step(2, a, 255 - a, f >> 1, f & 1);

    @(negedge clk);
    while (exp_q.size() > 0) compare_front();
    done = 1;
    report();
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule